// File: doc/BRIEF.md
# Test Waveform Sample Generator

This block computes fresh 12-bit sample codes for a small set of analogue test signals each time a sample strobe arrives (nominally every 125 us, i.e. 8 kHz). The first channel is a triangle: it climbs in fixed steps of 204 from zero to 4080 and then descends by the same step back to zero. It turns around on exact equality with those two end values, so one period spans 40 strobes. The second channel is a two-level square wave whose level follows one bit of a free-running tick counter. The result is two low samples, then two high samples.

The third channel is rebuilt from the word that the converter shifts back during each write. The 12-bit code field sits in bits 15 down to 4 of that 32-bit readback, so this channel repeats whatever code was sent in the previous command. A 16-bit sample counter runs alongside the channels, and its upper byte is brought out as a slow activity indication. All outputs change together one clock after the strobe. A one-cycle valid pulse marks the cycle in which the new values appear. The block does not decide when the converter is written.

Top module: `testwave_sampler`

## Requirements
- R1: While reset is high and after it is released, all three channel outputs, the sample counter, the activity byte and the valid strobe read zero, and the triangle direction is set to rising.
- R2: On each strobe with the triangle rising, the triangle output becomes the previous value plus 204; starting from reset, strobe n (n from 1 to 20) yields 204*n.
- R3: When a rising step lands exactly on 4080 (0xFF0), the direction becomes falling, so the next strobe yields 3876 (0xF24).
- R4: When a falling step lands exactly on 0, the direction becomes rising, so the next strobe yields 204 and the triangle repeats every 40 strobes.
- R5: The square output is 0x333 when bit 1 of an 8-bit square counter is 0 and 0xCCD when it is 1. The counter starts at 0 and increments after the level is chosen, so strobes 1 to 4 after reset give 0x333, 0x333, 0xCCD, 0xCCD.
- R6: On each strobe the echo channel takes bits [15:4] of the 32-bit readback input present at that strobe; the other 20 bits have no effect.
- R7: The 16-bit sample counter increments by one per strobe and wraps from 0xFFFF to 0x0000; the activity output equals its bits [15:8].
- R8: Outputs change only at the clock edge that samples the strobe high; valid is high for exactly the cycle that follows such an edge, and without a strobe no output changes whatever the readback input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample strobe, one clock wide per sample |
| echo_word | input | 32 | Readback word shifted out by the converter |
| tri_out | output | 12 | Triangle channel code |
| sq_out | output | 12 | Square channel code |
| echo_out | output | 12 | Channel rebuilt from the readback code field |
| sample_count | output | 16 | Strobe counter |
| activity | output | 8 | Upper byte of the strobe counter |
| valid | output | 1 | Pulses for one cycle when new values are present |

## Verification
The properties take for granted that the strobe is driven synchronously and that reset has been applied before the first strobe. They also take the readback word to be stable at the edge that samples the strobe. The stimulus changes every input on the falling clock edge and asserts reset from time zero. It raises the strobe either for single cycles or as one long unbroken burst to exercise counter wrap, so every strobe is seen at exactly one rising edge.

// File: rtl/testwave_pkg.sv
`timescale 1ns/1ps
package testwave_pkg;
    localparam int unsigned SAMPLE_W   = 12;
    localparam int unsigned ECHO_W     = 32;
    localparam int unsigned ECHO_LSB   = 4;
    localparam int unsigned TRI_STEP   = 204;
    localparam int unsigned TRI_PEAK   = 4080;
    localparam int unsigned SQ_LOW     = 'h333;
    localparam int unsigned SQ_HIGH    = 'hCCD;
    localparam int unsigned SQ_CNT_W   = 8;
    localparam int unsigned SQ_SEL_BIT = 1;
    localparam int unsigned COUNT_W    = 16;
    localparam int unsigned ACT_W      = 8;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic {SLOPE_UP = 1'b0, SLOPE_DOWN = 1'b1} slope_e;

    typedef struct packed {
        sample_t tri_v;
        sample_t sq_v;
        sample_t echo_v;
    } chan_set_t;

    function automatic sample_t code_field(input logic [ECHO_W-1:0] word);
        return word[ECHO_LSB +: SAMPLE_W];
    endfunction
endpackage

// File: rtl/tri_stepper.sv
`timescale 1ns/1ps
module tri_stepper
    import testwave_pkg::*;
#(
    parameter int unsigned W    = SAMPLE_W,
    parameter int unsigned STEP = TRI_STEP,
    parameter int unsigned PEAK = TRI_PEAK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] level
);
    localparam logic [W-1:0] STEP_V = W'(STEP);
    localparam logic [W-1:0] PEAK_V = W'(PEAK);

    slope_e       dir;
    logic [W-1:0] nxt;

    always_comb begin
        if (dir == SLOPE_DOWN) nxt = level - STEP_V;
        else                   nxt = level + STEP_V;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            dir   <= SLOPE_UP;
        end else if (adv) begin
            level <= nxt;
            if (dir == SLOPE_UP && nxt == PEAK_V)
                dir <= SLOPE_DOWN;
            else if (dir == SLOPE_DOWN && nxt == '0)
                dir <= SLOPE_UP;
        end
    end
endmodule

// File: rtl/square_stepper.sv
`timescale 1ns/1ps
module square_stepper
    import testwave_pkg::*;
#(
    parameter int unsigned W     = SAMPLE_W,
    parameter int unsigned CW    = SQ_CNT_W,
    parameter int unsigned SEL   = SQ_SEL_BIT,
    parameter int unsigned LOW   = SQ_LOW,
    parameter int unsigned HIGH  = SQ_HIGH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] level
);
    localparam logic [W-1:0] LOW_V  = W'(LOW);
    localparam logic [W-1:0] HIGH_V = W'(HIGH);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            phase <= '0;
        end else if (adv) begin
            level <= phase[SEL] ? HIGH_V : LOW_V;
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/echo_capture.sv
`timescale 1ns/1ps
module echo_capture
    import testwave_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [ECHO_W-1:0] word,
    output sample_t           level
);
    logic unused_bits;
    assign unused_bits = ^{word[ECHO_W-1:ECHO_LSB+SAMPLE_W], word[ECHO_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (rst)      level <= '0;
        else if (adv) level <= code_field(word);
    end
endmodule

// File: rtl/testwave_sampler.sv
`timescale 1ns/1ps
module testwave_sampler
    import testwave_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [ECHO_W-1:0]   echo_word,
    output logic [SAMPLE_W-1:0] tri_out,
    output logic [SAMPLE_W-1:0] sq_out,
    output logic [SAMPLE_W-1:0] echo_out,
    output logic [COUNT_W-1:0]  sample_count,
    output logic [ACT_W-1:0]    activity,
    output logic                valid
);
    localparam int unsigned ACT_LSB = COUNT_W - ACT_W;

    chan_set_t chans;

    tri_stepper #(.W(SAMPLE_W), .STEP(TRI_STEP), .PEAK(TRI_PEAK)) u_tri (
        .clk(clk), .rst(rst), .adv(tick), .level(chans.tri_v)
    );

    square_stepper #(.W(SAMPLE_W), .CW(SQ_CNT_W), .SEL(SQ_SEL_BIT),
                     .LOW(SQ_LOW), .HIGH(SQ_HIGH)) u_sq (
        .clk(clk), .rst(rst), .adv(tick), .level(chans.sq_v)
    );

    echo_capture u_echo (
        .clk(clk), .rst(rst), .adv(tick), .word(echo_word), .level(chans.echo_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_count <= '0;
            valid        <= 1'b0;
        end else begin
            valid <= tick;
            if (tick) sample_count <= sample_count + 1'b1;
        end
    end

    assign tri_out  = chans.tri_v;
    assign sq_out   = chans.sq_v;
    assign echo_out = chans.echo_v;
    assign activity = sample_count[ACT_LSB +: ACT_W];
endmodule

// File: rtl/testwave_sampler_chk.sv
`timescale 1ns/1ps
module testwave_sampler_chk
    import testwave_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                tick,
    input logic [ECHO_W-1:0]   echo_word,
    input logic [SAMPLE_W-1:0] tri_out,
    input logic [SAMPLE_W-1:0] sq_out,
    input logic [SAMPLE_W-1:0] echo_out,
    input logic [COUNT_W-1:0]  sample_count,
    input logic [ACT_W-1:0]    activity,
    input logic                valid
);
    localparam logic [SAMPLE_W-1:0] STEP_V = SAMPLE_W'(TRI_STEP);
    localparam logic [SAMPLE_W-1:0] PEAK_V = SAMPLE_W'(TRI_PEAK);
    localparam logic [SAMPLE_W-1:0] LOW_V  = SAMPLE_W'(SQ_LOW);
    localparam logic [SAMPLE_W-1:0] HIGH_V = SAMPLE_W'(SQ_HIGH);

    assert_tri_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (tri_out == $past(tri_out) + STEP_V) || (tri_out == $past(tri_out) - STEP_V));

    assert_tri_range_R3: assert property (@(posedge clk) disable iff (rst)
        tri_out <= PEAK_V);

    assert_sq_levels_R5: assert property (@(posedge clk) disable iff (rst)
        valid |-> (sq_out == LOW_V || sq_out == HIGH_V));

    assert_echo_field_R6: assert property (@(posedge clk) disable iff (rst)
        tick |=> echo_out == $past(echo_word[ECHO_LSB +: SAMPLE_W]));

    assert_count_inc_R7: assert property (@(posedge clk) disable iff (rst)
        tick |=> sample_count == $past(sample_count) + 1'b1);

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        tick |=> valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(tri_out) && $stable(sq_out) && $stable(echo_out)
                   && $stable(sample_count) && $stable(activity) && !valid));
endmodule

bind testwave_sampler testwave_sampler_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .echo_word(echo_word),
    .tri_out(tri_out), .sq_out(sq_out), .echo_out(echo_out),
    .sample_count(sample_count), .activity(activity), .valid(valid)
);

// File: tb/testwave_sampler_test.sv
`timescale 1ns/1ps
module testwave_sampler_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [31:0] echo_word = '0;
    logic [11:0] tri_out, sq_out, echo_out;
    logic [15:0] sample_count;
    logic [7:0]  activity;
    logic        valid;

    int checks = 0;
    int failures = 0;
    int n = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    testwave_sampler uut (
        .clk(clk), .rst(rst), .tick(tick), .echo_word(echo_word),
        .tri_out(tri_out), .sq_out(sq_out), .echo_out(echo_out),
        .sample_count(sample_count), .activity(activity), .valid(valid)
    );

    // readback word and its expected code field (bits 15:4)
    localparam logic [43:0] VEC [8] = '{
        {32'h0032CCD0, 12'hCCD}, {32'h00323330, 12'h333},
        {32'hFFFFFFFF, 12'hFFF}, {32'h00000000, 12'h000},
        {32'h1234ABCD, 12'hABC}, {32'hFFFF000F, 12'h000},
        {32'h0000FFF0, 12'hFFF}, {32'h8765A5A5, 12'hA5A}
    };

    function automatic int tri_exp(input int k);
        int p = k % 40;
        return (p <= 20) ? 204 * p : 204 * (40 - p);
    endfunction

    function automatic int sq_exp(input int k);
        if (k == 0) return 0;
        return (((k - 1) >> 1) & 1) ? 'hCCD : 'h333;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (tick %0d)", req, act, exp, n);
        end
    endtask

    task automatic do_tick(input logic [31:0] w);
        @(negedge clk);
        tick = 1'b1;
        echo_word = w;
        @(negedge clk);
        tick = 1'b0;
        n++;
    endtask

    task automatic check_model();
        check("R2/R3/R4 triangle", 32'(tri_out), 32'(tri_exp(n)));
        check("R5 square", 32'(sq_out), 32'(sq_exp(n)));
        check("R7 counter", 32'(sample_count), 32'(n % 65536));
        check("R7 activity", 32'(activity), 32'((n % 65536) >> 8));
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n = 0;
    endtask

    initial begin
        logic [11:0] held;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 tri", 32'(tri_out), 0);
        check("R1 sq", 32'(sq_out), 0);
        check("R1 echo", 32'(echo_out), 0);
        check("R1 count", 32'(sample_count), 0);
        check("R1 activity", 32'(activity), 0);
        check("R1 valid", 32'(valid), 0);
        rst = 1'b0;
        @(negedge clk);

        // table walk: R6 echo field plus model checks
        for (int i = 0; i < 8; i++) begin
            do_tick(VEC[i][43:12]);
            check("R8 valid high", 32'(valid), 1);
            check("R6 echo", 32'(echo_out), 32'(VEC[i][11:0]));
            check_model();
        end

        // R8: valid lasts one cycle; no change without a tick
        held = echo_out;
        @(negedge clk);
        check("R8 valid low", 32'(valid), 0);
        echo_word = 32'h0005A5A0;
        repeat (3) @(negedge clk);
        check("R8 echo held", 32'(echo_out), 32'(held));
        check("R6/R8 no tick", 32'(sample_count), 32'(n));
        check_model();

        // triangle through both reversals
        while (n < 45) begin
            do_tick(32'h0);
            check_model();
            if (n == 20) check("R3 peak", 32'(tri_out), 32'h0FF0);
            if (n == 21) check("R3 reverse", 32'(tri_out), 32'h0F24);
            if (n == 40) check("R4 zero", 32'(tri_out), 0);
            if (n == 41) check("R4 rise", 32'(tri_out), 204);
        end

        // R1: reset while falling clears the direction
        while (n < 65) do_tick(32'h0);
        check("R4 falling", 32'(tri_out), 32'(tri_exp(65)));
        apply_reset();
        check("R1 tri after reset", 32'(tri_out), 0);
        do_tick(32'h0);
        check("R1 slope up", 32'(tri_out), 204);
        check("R5 first low", 32'(sq_out), 32'h333);

        // R7: long burst up to counter wrap
        @(negedge clk);
        tick = 1'b1;
        repeat (65534) @(negedge clk);
        tick = 1'b0;
        n += 65534;
        check("R7 full", 32'(sample_count), 32'hFFFF);
        check("R7 act full", 32'(activity), 32'hFF);
        check_model();
        do_tick(32'h0);
        check("R7 wrap", 32'(sample_count), 0);
        check("R7 act wrap", 32'(activity), 0);
        check_model();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #900000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule